// File: doc/BRIEF.md
# Discrete-Input Sensor SPI Register Slave

This block is the serial register front end of a 32-channel discrete-input threshold sensor. A host talks to it over a mode-0 SPI link, with SCLK idle low and data sampled on the rising edge. Each transaction starts with a command byte. Bit 7 of that byte is the direction flag and the low seven bits are the register address. Zero, one or two data bytes follow for a write. For a read, the slave shifts out as many bytes as the host clocks. Values wider than a byte travel most-significant byte first.

The block holds the sensor configuration and drives it to the sensing logic on plain output ports:
- a control register with a test-mode enable and a soft-reset bit;
- one sensing-mode bit per bank of eight channels;
- two 16-bit threshold words, one for ground-open sensing and one for supply-open sensing. The high byte of each word is the hysteresis and the low byte is the sum of the two thresholds.

The live channel states arrive on a 32-bit input. The host can read them one bank at a time, or as one big-endian 4-byte word. The word is a snapshot taken when the command byte completes.

The SPI pins are oversampled in the system clock domain. SCLK must therefore stay high and low for at least four system clocks each.

Top module: `dsi_spi_regfile`

## Requirements
- R1: The first byte after chip select falls is the command. Bit 7 set means read and bit 7 clear means write; bits 6:0 are the address. A command of 0x84 is a read of 0x04, and data bytes sent after it change nothing.
- R2: Every byte moves MSB first. A 16-bit or 32-bit value is sent and returned most-significant byte first.
- R3: After reset:
  - the control register is 0;
  - the sensing-mode register is 0;
  - both threshold words are 0x0206;
  - MISO is 0 while chip select is high.
- R4: The control register is at 0x02. Bit 0 drives `test_mode` and bit 1 is soft reset. Bits 7:2 read back as 0.
- R5: The sensing-mode register is at 0x04. Bit n drives `sense_mode[n]` for channels 8n to 8n+7, where 0 selects ground-open and 1 selects supply-open. Bits 7:4 read back as 0.
- R6: The ground-open threshold word is at 0x3A and the supply-open threshold word is at 0x3C. A write takes effect only when both data bytes have arrived, and it leaves the other word unchanged.
- R7: A one-byte read of 0x10, 0x12, 0x14 or 0x16 returns channels 7..0, 15..8, 23..16 or 31..24 respectively, with the higher channel in the MSB.
- R8: A 4-byte read of 0x78 returns channels 31..0 as captured when the command byte completed. Later changes on `chan_in` during the burst do not show.
- R9: Raising chip select in the middle of a transaction discards it. A 16-bit write cut off after one data byte changes nothing, and the next transaction decodes a fresh command.
- R10: Writing 1 to control bit 1 returns sensing mode and both thresholds to their reset values. While that bit stays 1, writes to those registers are ignored. Writing 0 to the control register then restores normal writes.
- R11: A write to an unmapped address is ignored. A read from an unmapped address returns 0x00, and so does any byte read past the end of a register.
- R12: MISO changes only after a falling SCLK edge. It is stable for the whole high phase of SCLK, and the first bit of read data is valid before the first rising edge of the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, 0 when not selected |
| chan_in | input | 32 | Live channel states, bit n is channel n |
| test_mode | output | 1 | Control register bit 0 |
| sense_mode | output | 4 | Sensing mode per bank of eight channels |
| thr_gnd | output | 16 | Ground-open threshold word |
| thr_sup | output | 16 | Supply-open threshold word |

## Verification
Configuration state is visible both on the output ports and by reading it back over SPI. A wrong register value therefore shows on `sense_mode`, `test_mode` or the threshold outputs a few system clocks after the last bit of the write, and again in the next read. A slip in the bit or byte counters corrupts the very next byte on MISO. For example, a read returns a shifted byte, or a write lands one byte early. Because of this, each transaction is read back immediately, and the cut-off write and soft-reset sequences are each followed by a read in the next frame.

// File: rtl/dsi_pkg.sv
// Package: shared address map and register-kind type for the discrete-input
// sensor SPI register slave. Addresses are fixed by the host software.
package dsi_pkg;
    localparam logic [6:0] ADDR_CTRL    = 7'h02;
    localparam logic [6:0] ADDR_MODE    = 7'h04;
    localparam logic [6:0] ADDR_STATE0  = 7'h10;
    localparam logic [6:0] ADDR_THR_GND = 7'h3A;
    localparam logic [6:0] ADDR_THR_SUP = 7'h3C;
    localparam logic [6:0] ADDR_WORD    = 7'h78;

    typedef enum logic [2:0] {
        K_NONE,
        K_CTRL,
        K_MODE,
        K_THR_GND,
        K_THR_SUP,
        K_STATE,
        K_WORD
    } reg_kind_e;
endpackage

// File: rtl/dsi_in_sync.sv
// Module: dsi_in_sync
// Brings the asynchronous SPI pins into the system clock domain through a
// STAGES-deep flop chain and derives single-cycle SCLK edge strobes.
// Assumes SCLK high and low phases each last at least STAGES+2 system clocks.
module dsi_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic mosi_i,
    input  logic cs_n_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s,
    output logic cs_act
);
    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] mosi_p;
    logic [STAGES-1:0] csn_p;
    logic              sclk_prev;

    // Synchronizer chains plus the delayed SCLK used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p    <= '0;
            mosi_p    <= '0;
            csn_p     <= '1;
            sclk_prev <= 1'b0;
        end else begin
            sclk_p    <= {sclk_p[STAGES-2:0], sclk_i};
            mosi_p    <= {mosi_p[STAGES-2:0], mosi_i};
            csn_p     <= {csn_p[STAGES-2:0], cs_n_i};
            sclk_prev <= sclk_p[STAGES-1];
        end
    end

    assign sclk_rise = sclk_p[STAGES-1] & ~sclk_prev;
    assign sclk_fall = ~sclk_p[STAGES-1] & sclk_prev;
    assign mosi_s    = mosi_p[STAGES-1];
    assign cs_act    = ~csn_p[STAGES-1];
endmodule

// File: rtl/dsi_framer.sv
// Module: dsi_framer
// Mode-0 bit/byte framing: shifts MOSI in on SCLK rises, reports each
// completed byte with its index in the frame, and shifts the byte offered on
// tx_byte out on MISO, changing only on SCLK falls. Chip select inactive
// clears all frame state, so a partial frame leaves nothing behind.
module dsi_framer #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             mosi_s,
    input  logic             cs_act,
    input  logic [7:0]       tx_byte,
    output logic             byte_done,
    output logic [7:0]       rx_byte,
    output logic [IDX_W-1:0] byte_idx,
    output logic             miso
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [2:0] bit_cnt;
    logic [6:0] rx_sr;
    logic [7:0] tx_sr;

    assign byte_done = cs_act & sclk_rise & (bit_cnt == 3'd7);
    assign rx_byte   = {rx_sr, mosi_s};

    // Receive shifter, bit counter and byte index, all cleared outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            byte_idx <= '0;
        end else if (!cs_act) begin
            bit_cnt  <= '0;
            rx_sr    <= '0;
            byte_idx <= '0;
        end else if (sclk_rise) begin
            rx_sr   <= rx_byte[6:0];
            bit_cnt <= bit_cnt + 3'd1;
            if (byte_done && byte_idx != IDX_MAX) begin
                byte_idx <= byte_idx + 1'b1;
            end
        end
    end

    // Transmit shifter: loads a new byte on the fall that follows a byte boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr <= '0;
            miso  <= 1'b0;
        end else if (!cs_act) begin
            tx_sr <= '0;
            miso  <= 1'b0;
        end else if (sclk_fall) begin
            if (bit_cnt == 3'd0 && byte_idx != '0) begin
                miso  <= tx_byte[7];
                tx_sr <= {tx_byte[6:0], 1'b0};
            end else begin
                miso  <= tx_sr[7];
                tx_sr <= {tx_sr[6:0], 1'b0};
            end
        end
    end

    // R3: MISO is driven low once the slave is deselected.
    a_r3_miso_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso);
    // R12: MISO holds its value in every cycle without a falling SCLK edge.
    a_r12_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && !sclk_fall) |=> $stable(miso));
    // R9: a deselect restarts byte numbering for the next frame.
    a_r9_idx_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (byte_idx == '0));
endmodule

// File: rtl/dsi_regbank.sv
// Module: dsi_regbank
// Register storage, address decode, write commit and read-data selection.
// Assumes NCH is a multiple of 8 no larger than 64, so one byte holds all
// bank mode bits. Channel inputs are synchronized and snapshotted at the end
// of each command byte.
module dsi_regbank
    import dsi_pkg::*;
#(
    parameter int          NCH     = 32,
    parameter int          IDX_W   = 3,
    parameter logic [15:0] THR_RST = 16'h0206,
    localparam int         NBANK   = NCH / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_act,
    input  logic             byte_done,
    input  logic [7:0]       rx_byte,
    input  logic [IDX_W-1:0] byte_idx,
    input  logic [NCH-1:0]   chan_i,
    output logic [7:0]       tx_byte,
    output logic             test_mode,
    output logic [NBANK-1:0] sense_mode,
    output logic [15:0]      thr_gnd,
    output logic [15:0]      thr_sup
);
    logic [6:0]       addr_q;
    logic             rd_q;
    logic [7:0]       wbuf_q;
    logic [1:0]       ctrl_q;
    logic [NBANK-1:0] mode_q;
    logic [15:0]      thr_g_q;
    logic [15:0]      thr_s_q;
    logic [NCH-1:0]   chan_m;
    logic [NCH-1:0]   chan_s;
    logic [NCH-1:0]   snap_q;
    reg_kind_e        kind;
    logic [7:0]       bank_byte;
    logic [7:0]       mode_byte;
    logic [7:0]       word_byte;
    logic [IDX_W-1:0] rd_k;
    logic             wr8;
    logic             wr16;

    // Address decode of the latched command into a register kind and bank byte.
    always_comb begin
        kind      = K_NONE;
        bank_byte = '0;
        unique case (addr_q)
            ADDR_CTRL:    kind = K_CTRL;
            ADDR_MODE:    kind = K_MODE;
            ADDR_THR_GND: kind = K_THR_GND;
            ADDR_THR_SUP: kind = K_THR_SUP;
            ADDR_WORD:    kind = K_WORD;
            default:      kind = K_NONE;
        endcase
        for (int b = 0; b < NBANK; b++) begin
            if (addr_q == ADDR_STATE0 + 7'(2 * b)) begin
                kind      = K_STATE;
                bank_byte = snap_q[8*b +: 8];
            end
        end
    end

    assign wr8  = byte_done && !rd_q && (byte_idx == IDX_W'(1))
                  && (kind == K_CTRL || kind == K_MODE);
    assign wr16 = byte_done && !rd_q && (byte_idx == IDX_W'(2))
                  && (kind == K_THR_GND || kind == K_THR_SUP);

    // Channel input synchronizer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_m <= '0;
            chan_s <= '0;
        end else begin
            chan_m <= chan_i;
            chan_s <= chan_m;
        end
    end

    // Per-frame state: command latch, channel snapshot, first write byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rd_q   <= 1'b0;
            wbuf_q <= '0;
            snap_q <= '0;
        end else if (byte_done) begin
            if (byte_idx == '0) begin
                rd_q   <= rx_byte[7];
                addr_q <= rx_byte[6:0];
                snap_q <= chan_s;
            end else if (byte_idx == IDX_W'(1)) begin
                wbuf_q <= rx_byte;
            end
        end
    end

    // Configuration registers, with soft reset taking precedence over writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            mode_q  <= '0;
            thr_g_q <= THR_RST;
            thr_s_q <= THR_RST;
        end else if (wr8 && kind == K_CTRL) begin
            ctrl_q <= rx_byte[1:0];
            if (rx_byte[1]) begin
                mode_q  <= '0;
                thr_g_q <= THR_RST;
                thr_s_q <= THR_RST;
            end
        end else if (!ctrl_q[1]) begin
            if (wr8 && kind == K_MODE) begin
                mode_q <= rx_byte[NBANK-1:0];
            end
            if (wr16 && kind == K_THR_GND) begin
                thr_g_q <= {wbuf_q, rx_byte};
            end
            if (wr16 && kind == K_THR_SUP) begin
                thr_s_q <= {wbuf_q, rx_byte};
            end
        end
    end

    // Read data selection: byte k of the addressed register, big-endian.
    always_comb begin
        rd_k      = byte_idx - IDX_W'(1);
        mode_byte = '0;
        mode_byte[NBANK-1:0] = mode_q;
        word_byte = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (rd_k == IDX_W'(b)) begin
                word_byte = snap_q[8*(NBANK-1-b) +: 8];
            end
        end
        tx_byte = '0;
        if (rd_q) begin
            unique case (kind)
                K_CTRL:    tx_byte = (rd_k == '0) ? {6'b0, ctrl_q} : 8'h00;
                K_MODE:    tx_byte = (rd_k == '0) ? mode_byte : 8'h00;
                K_THR_GND: tx_byte = (rd_k == '0) ? thr_g_q[15:8] :
                                     (rd_k == IDX_W'(1)) ? thr_g_q[7:0] : 8'h00;
                K_THR_SUP: tx_byte = (rd_k == '0) ? thr_s_q[15:8] :
                                     (rd_k == IDX_W'(1)) ? thr_s_q[7:0] : 8'h00;
                K_STATE:   tx_byte = (rd_k == '0) ? bank_byte : 8'h00;
                K_WORD:    tx_byte = word_byte;
                default:   tx_byte = 8'h00;
            endcase
        end
    end

    assign test_mode  = ctrl_q[0];
    assign sense_mode = mode_q;
    assign thr_gnd    = thr_g_q;
    assign thr_sup    = thr_s_q;

    // R3: registers leave reset at their defined defaults.
    a_r3_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (thr_g_q == THR_RST && thr_s_q == THR_RST
                           && mode_q == '0 && ctrl_q == '0));
    // R10: while soft reset is held, the other registers stay at defaults.
    a_r10_srst_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[1] |-> (mode_q == '0 && thr_g_q == THR_RST && thr_s_q == THR_RST));
    // R6: threshold words move only on a completed two-byte write or soft reset.
    a_r6_thr_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr16 && !wr8) |=> ($stable(thr_g_q) && $stable(thr_s_q)));
    // R9: no register write happens outside a selected frame.
    a_r9_commit_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (wr8 || wr16) |-> cs_act);
    // R11: unmapped addresses read as zero.
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NONE) |-> (tx_byte == 8'h00));
endmodule

// File: rtl/dsi_spi_regfile.sv
// Module: dsi_spi_regfile (top)
// SPI mode-0 register slave for a discrete-input threshold sensor: pin
// synchronizer, byte framer and register bank. All logic runs on clk; the
// SPI pins are oversampled, so SCLK must be slow against clk.
module dsi_spi_regfile #(
    parameter int          NCH         = 32,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] THR_RST     = 16'h0206,
    localparam int         NBANK       = NCH / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic             spi_miso,
    input  logic [NCH-1:0]   chan_in,
    output logic             test_mode,
    output logic [NBANK-1:0] sense_mode,
    output logic [15:0]      thr_gnd,
    output logic [15:0]      thr_sup
);
    localparam int IDX_W = 3;

    logic             sclk_rise;
    logic             sclk_fall;
    logic             mosi_s;
    logic             cs_act;
    logic             byte_done;
    logic [7:0]       rx_byte;
    logic [7:0]       tx_byte;
    logic [IDX_W-1:0] byte_idx;

    dsi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (spi_sclk),
        .mosi_i    (spi_mosi),
        .cs_n_i    (spi_cs_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .cs_act    (cs_act)
    );

    dsi_framer #(.IDX_W(IDX_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .cs_act    (cs_act),
        .tx_byte   (tx_byte),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .byte_idx  (byte_idx),
        .miso      (spi_miso)
    );

    dsi_regbank #(.NCH(NCH), .IDX_W(IDX_W), .THR_RST(THR_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .byte_idx   (byte_idx),
        .chan_i     (chan_in),
        .tx_byte    (tx_byte),
        .test_mode  (test_mode),
        .sense_mode (sense_mode),
        .thr_gnd    (thr_gnd),
        .thr_sup    (thr_sup)
    );
endmodule

// File: tb/tb_dsi_spi_regfile.sv
module tb_dsi_spi_regfile;
    localparam int HALF = 8;
    localparam int NV   = 19;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic [31:0] chan = '0;
    logic        test_mode;
    logic [3:0]  sense_mode;
    logic [15:0] thr_gnd;
    logic [15:0] thr_sup;

    int          nchk = 0;
    int          nfail = 0;
    logic [7:0]  txb [0:5];
    logic [7:0]  rxb [0:5];
    logic        glitch;
    logic [31:0] rv;

    always #2 clk = ~clk;

    dsi_spi_regfile dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .chan_in(chan),
        .test_mode(test_mode), .sense_mode(sense_mode),
        .thr_gnd(thr_gnd), .thr_sup(thr_sup)
    );

    // Vector: {read, addr[6:0], nbytes[2:0], wdata[15:0], chan[31:0], expect[31:0]}
    localparam logic [90:0] VEC [0:NV-1] = '{
        {1'b0, 7'h04, 3'd1, 16'h0005, 32'h0, 32'h0},                  // R5 write
        {1'b1, 7'h04, 3'd1, 16'h0000, 32'h0, 32'h05},                 // R5
        {1'b0, 7'h3A, 3'd2, 16'h0814, 32'h0, 32'h0},                  // R6 write
        {1'b1, 7'h3A, 3'd2, 16'h0000, 32'h0, 32'h0814},               // R6 R2
        {1'b0, 7'h3C, 3'd2, 16'h0A1E, 32'h0, 32'h0},                  // R6 write
        {1'b1, 7'h3C, 3'd2, 16'h0000, 32'h0, 32'h0A1E},               // R6
        {1'b1, 7'h3A, 3'd2, 16'h0000, 32'h0, 32'h0814},               // R6 other word kept
        {1'b1, 7'h10, 3'd1, 16'h0000, 32'hA1B2C3D4, 32'hD4},          // R7
        {1'b1, 7'h12, 3'd1, 16'h0000, 32'hA1B2C3D4, 32'hC3},          // R7
        {1'b1, 7'h14, 3'd1, 16'h0000, 32'hA1B2C3D4, 32'hB2},          // R7
        {1'b1, 7'h16, 3'd1, 16'h0000, 32'hA1B2C3D4, 32'hA1},          // R7
        {1'b1, 7'h78, 3'd4, 16'h0000, 32'h12345678, 32'h12345678},    // R8 R2
        {1'b0, 7'h02, 3'd1, 16'h00FD, 32'h0, 32'h0},                  // R4 write
        {1'b1, 7'h02, 3'd1, 16'h0000, 32'h0, 32'h01},                 // R4
        {1'b0, 7'h55, 3'd1, 16'h00FF, 32'h0, 32'h0},                  // R11 write
        {1'b1, 7'h55, 3'd1, 16'h0000, 32'h0, 32'h00},                 // R11
        {1'b1, 7'h04, 3'd2, 16'h0000, 32'h0, 32'h0500},               // R11 past end
        {1'b0, 7'h04, 3'd1, 16'h00FF, 32'h0, 32'h0},                  // R5 write
        {1'b1, 7'h04, 3'd1, 16'h0000, 32'h0, 32'h0F}                  // R5 upper bits 0
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Mode-0 master: nb bytes from txb, received bytes into rxb.
    task automatic xfer(input int nb);
        glitch = 1'b0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic pre;
                mosi = txb[i][b];
                repeat (HALF) @(negedge clk);
                pre = miso;
                rxb[i][b] = pre;
                sclk = 1'b1;
                repeat (HALF) @(negedge clk);
                if (miso !== pre) glitch = 1'b1;
                sclk = 1'b0;
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        mosi = 1'b0;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic spi_wr(input logic [7:0] cmd, input int nb, input logic [15:0] wd);
        txb[0] = cmd;
        txb[1] = (nb == 2) ? wd[15:8] : wd[7:0];
        txb[2] = wd[7:0];
        xfer(nb + 1);
    endtask

    task automatic spi_rd(input logic [6:0] addr, input int nb, output logic [31:0] val);
        txb[0] = {1'b1, addr};
        for (int i = 1; i < 6; i++) txb[i] = 8'h00;
        xfer(nb + 1);
        val = '0;
        for (int i = 1; i <= nb; i++) val = {val[23:0], rxb[i]};
        chk(!glitch, "R12 miso moved while SCLK high", {31'b0, glitch}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", 150000, 150000);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R3 reset state at the ports and over SPI.
        chk(thr_gnd == 16'h0206, "R3 thr_gnd", {16'h0, thr_gnd}, 32'h0206);
        chk(thr_sup == 16'h0206, "R3 thr_sup", {16'h0, thr_sup}, 32'h0206);
        chk(sense_mode == 4'h0 && test_mode == 1'b0, "R3 mode/test",
            {27'h0, test_mode, sense_mode}, 32'h0);
        chk(miso == 1'b0, "R3 miso idle", {31'h0, miso}, 32'h0);
        spi_rd(7'h3C, 2, rv);
        chk(rv == 32'h0206, "R3 read supply threshold", rv, 32'h0206);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            logic [90:0] e;
            e = VEC[v];
            chan = e[63:32];
            if (e[90]) begin
                spi_rd(e[89:83], int'(e[82:80]), rv);
                chk(rv == e[31:0], $sformatf("vector %0d addr %h", v, e[89:83]), rv, e[31:0]);
            end else begin
                spi_wr({1'b0, e[89:83]}, int'(e[82:80]), e[79:64]);
            end
        end
        chk(test_mode == 1'b1, "R4 test_mode port", {31'h0, test_mode}, 32'h1);
        chk(sense_mode == 4'hF, "R5 sense_mode port", {28'h0, sense_mode}, 32'hF);
        chk(thr_gnd == 16'h0814 && thr_sup == 16'h0A1E, "R6 threshold ports",
            {thr_gnd, thr_sup}, 32'h08140A1E);

        // R1: read command with trailing data does not write.
        spi_wr(8'h84, 1, 16'h0003);
        chk(sense_mode == 4'hF, "R1 read flag blocks write", {28'h0, sense_mode}, 32'hF);

        // R9: 16-bit write cut after one data byte is discarded.
        txb[0] = 8'h3A; txb[1] = 8'h44;
        xfer(2);
        chk(thr_gnd == 16'h0814, "R9 aborted write port", {16'h0, thr_gnd}, 32'h0814);
        spi_rd(7'h3A, 2, rv);
        chk(rv == 32'h0814, "R9 aborted write readback", rv, 32'h0814);

        // R8: channel change during the burst does not show.
        chan = 32'hCAFE0123;
        fork
            spi_rd(7'h78, 4, rv);
            begin
                repeat (40 * HALF) @(negedge clk);
                chan = 32'h0F0F0F0F;
            end
        join
        chk(rv == 32'hCAFE0123, "R8 word snapshot", rv, 32'hCAFE0123);

        // R10: soft reset, writes ignored while held, release restores writes.
        spi_wr(8'h02, 1, 16'h0002);
        chk(sense_mode == 4'h0 && test_mode == 1'b0, "R10 srst mode",
            {27'h0, test_mode, sense_mode}, 32'h0);
        chk(thr_gnd == 16'h0206 && thr_sup == 16'h0206, "R10 srst thresholds",
            {thr_gnd, thr_sup}, 32'h02060206);
        spi_wr(8'h04, 1, 16'h0003);
        spi_rd(7'h04, 1, rv);
        chk(rv == 32'h0, "R10 write ignored during srst", rv, 32'h0);
        spi_wr(8'h02, 1, 16'h0000);
        spi_wr(8'h04, 1, 16'h0003);
        spi_rd(7'h04, 1, rv);
        chk(rv == 32'h03, "R10 write after release", rv, 32'h03);
        chk(miso == 1'b0, "R3 miso idle after frames", {31'h0, miso}, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule